// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins. The pins are grouped into banks of 32. Every configuration register is repeated once per bank at consecutive word addresses. A per-pin enable, a direction bit and an output-data bit together decide whether the pin drives its pad and what value it drives. Pad levels pass through a two-flop synchroniser and can always be read back.

Each pin can raise an interrupt on either a rising or a falling edge of its synchronised level. The pin must be enabled and not masked for its pending bit to set. Pending bits are cleared by writing zeros to them. A single interrupt output combines every pending bit in every bank. When the pin count is not a multiple of 32, the spare bits of the last bank still hold whatever is written to the configuration registers. They never take part in interrupts.

Access is through a simple synchronous register port. A request lasts one cycle. Write data is taken in that cycle, and read data appears on the following cycle.

Top module: `gpio_banked`

## Requirements
- R1: After reset every register reads 0, `pad_oe`, `pad_out` and `irq` are 0, and no status bit is pending.
- R2: The word address is {register code (3 bits), bank index (`BSEL_W` bits)}. The codes are: 0 enable, 1 output data, 2 direction, 3 input level, 4 mask, 5 status, 6 edge select, 7 unused. A read taken with `req_valid` high and `req_write` low returns its word on `rd_data` after the next rising edge. `rd_data` is 0 in cycles that follow no read.
- R3: A pin drives its pad (`pad_oe` = 1) only when its enable bit is 1 and its direction bit is 0. `pad_out` carries the output-data bit while the pin drives and is 0 otherwise.
- R4: The input-level register returns the pad level after two clock edges of synchronisation, whatever the pin's enable or direction.
- R5: Edge select 1 makes a pin detect rising edges and 0 makes it detect falling edges. A detected edge sets the status bit on the third rising clock edge after the pad changes, and `irq` rises with it.
- R6: An edge sets no status bit while the pin's mask bit is 1 or its enable bit is 0.
- R7: Writing the status register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R8: When an edge sets a status bit in the same cycle as a write clears it, the bit ends set.
- R9: In the last bank, bits at or above the pin count hold written values in the configuration registers and never show as pending.
- R10: `irq` is 1 exactly when at least one status bit in any bank is pending.
- R11: Writes to the input-level register and to code 7 change nothing. Code 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Word address {code, bank} |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after the request |
| pad_in | input | NUM_PINS | Raw pad levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The edge logic is driven with both edge polarities on the same pin. This shows that a falling change cannot fire a rising-configured pin, and that a rising change cannot fire a falling-configured one. The same toggles are then repeated with the pin masked, and again with the pin disabled, to separate the two gating conditions. A status clear is aimed at the exact cycle of a new edge to show the set-wins ordering. A pin in the partly used last bank shows that its spare bits stay quiet while still storing data. Pins configured as outputs are also driven from the pad side, to show that the level readback ignores direction.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BANK_W = 32;

  typedef enum logic [2:0] {
    RC_ENABLE  = 3'd0,
    RC_OUTDATA = 3'd1,
    RC_DIR     = 3'd2,
    RC_LEVEL   = 3'd3,
    RC_MASK    = 3'd4,
    RC_STATUS  = 3'd5,
    RC_EDGE    = 3'd6,
    RC_NONE    = 3'd7
  } regcode_e;

  function automatic int bank_count(input int pins);
    return (pins + BANK_W - 1) / BANK_W;
  endfunction

  // bits of bank 'bank' that correspond to real pins
  function automatic logic [BANK_W-1:0] live_mask(input int pins, input int bank);
    int n;
    n = pins - bank * BANK_W;
    if (n >= BANK_W) return '1;
    else if (n <= 0) return '0;
    else return (BANK_W'(1) << n) - BANK_W'(1);
  endfunction

  // per-pin edge match: sel=1 rising, sel=0 falling
  function automatic logic [BANK_W-1:0] edge_hit(input logic [BANK_W-1:0] now_lvl,
                                                 input logic [BANK_W-1:0] old_lvl,
                                                 input logic [BANK_W-1:0] sel);
    return (sel & now_lvl & ~old_lvl) | (~sel & ~now_lvl & old_lvl);
  endfunction

  // write-zero-to-clear with set priority
  function automatic logic [BANK_W-1:0] status_next(input logic [BANK_W-1:0] cur,
                                                    input logic [BANK_W-1:0] set,
                                                    input logic              clr_en,
                                                    input logic [BANK_W-1:0] keep);
    logic [BANK_W-1:0] k;
    k = clr_en ? keep : '1;
    return (cur & k) | set;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      sync_o   <= '0;
    end else begin
      stage1_q <= raw_i;
      sync_o   <= stage1_q;
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter logic [BANK_W-1:0] LIVE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        wr_stb,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] lvl,
  output logic [BANK_W-1:0] en_o,
  output logic [BANK_W-1:0] dout_o,
  output logic [BANK_W-1:0] dir_o,
  output logic [BANK_W-1:0] mask_o,
  output logic [BANK_W-1:0] edge_o,
  output logic [BANK_W-1:0] stat_o,
  output logic              pend_o
);
  logic [BANK_W-1:0] prev_q;
  logic [BANK_W-1:0] hit_w;
  logic [BANK_W-1:0] set_w;
  logic [BANK_W-1:0] stat_d;
  logic              clr_w;

  assign clr_w = wr_stb[RC_STATUS];

  always_comb begin
    hit_w  = edge_hit(lvl, prev_q, edge_o);
    set_w  = hit_w & en_o & ~mask_o & LIVE;
    stat_d = status_next(stat_o, set_w, clr_w, wdata) & LIVE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o   <= '0;
      dout_o <= '0;
      dir_o  <= '0;
      mask_o <= '0;
      edge_o <= '0;
      stat_o <= '0;
      prev_q <= '0;
    end else begin
      if (wr_stb[RC_ENABLE])  en_o   <= wdata;
      if (wr_stb[RC_OUTDATA]) dout_o <= wdata;
      if (wr_stb[RC_DIR])     dir_o  <= wdata;
      if (wr_stb[RC_MASK])    mask_o <= wdata;
      if (wr_stb[RC_EDGE])    edge_o <= wdata;
      stat_o <= stat_d;
      prev_q <= lvl;
    end
  end

  assign pend_o = |stat_o;

  AST_NEW_PEND_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_o & ~$past(stat_o)) & ~$past(en_o & ~mask_o & LIVE)) == '0); // R6
  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && set_w == '0) |=> stat_o == ($past(stat_o) & $past(wdata))); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_w && set_w == '0) |=> stat_o == $past(stat_o)); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w != '0) |=> (stat_o & $past(set_w)) == $past(set_w)); // R8
  AST_RO_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb[RC_LEVEL] || wr_stb[RC_NONE])); // R11
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_bank_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BSEL_W = 2,
  localparam int VW    = NB * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [2:0]        code,
  input  logic [BSEL_W-1:0] bank,
  input  logic [VW-1:0]     en_v,
  input  logic [VW-1:0]     dout_v,
  input  logic [VW-1:0]     dir_v,
  input  logic [VW-1:0]     lvl_v,
  input  logic [VW-1:0]     mask_v,
  input  logic [VW-1:0]     stat_v,
  input  logic [VW-1:0]     edge_v,
  output logic [BANK_W-1:0] rd_data
);
  logic [BANK_W-1:0] word_w;

  always_comb begin
    int bi;
    bi = int'(bank);
    word_w = '0;
    if (bi < NB) begin
      case (code)
        RC_ENABLE:  word_w = en_v[bi*BANK_W +: BANK_W];
        RC_OUTDATA: word_w = dout_v[bi*BANK_W +: BANK_W];
        RC_DIR:     word_w = dir_v[bi*BANK_W +: BANK_W];
        RC_LEVEL:   word_w = lvl_v[bi*BANK_W +: BANK_W];
        RC_MASK:    word_w = mask_v[bi*BANK_W +: BANK_W];
        RC_STATUS:  word_w = stat_v[bi*BANK_W +: BANK_W];
        RC_EDGE:    word_w = edge_v[bi*BANK_W +: BANK_W];
        default:    word_w = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_en ? word_w : '0;
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0); // R2
endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 102,
  parameter int BSEL_W   = ($clog2((NUM_PINS + 31) / 32) > 0) ? $clog2((NUM_PINS + 31) / 32) : 1,
  parameter int ADDR_W   = 3 + BSEL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [31:0]         req_wdata,
  output logic [31:0]         rd_data,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq
);
  localparam int NB = bank_count(NUM_PINS);
  localparam int VW = NB * BANK_W;

  logic [2:0]          code_w;
  logic [BSEL_W-1:0]   bank_w;
  logic                wr_go;
  logic                rd_go;
  logic [NUM_PINS-1:0] sync_w;
  logic [VW-1:0]       lvl_v;
  logic [VW-1:0]       en_v, dout_v, dir_v, mask_v, stat_v, edge_v;
  logic [VW-1:0]       drive_v;
  logic [NB-1:0]       pend_v;

  assign code_w = req_addr[ADDR_W-1:BSEL_W];
  assign bank_w = req_addr[BSEL_W-1:0];
  assign wr_go  = req_valid & req_write;
  assign rd_go  = req_valid & ~req_write;

  gpio_in_sync #(.W(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pad_in),
    .sync_o (sync_w)
  );

  always_comb begin
    lvl_v = '0;
    lvl_v[NUM_PINS-1:0] = sync_w;
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [7:0] stb_w;
    for (genvar c = 0; c < 8; c++) begin : g_stb
      if (c == int'(RC_LEVEL) || c == int'(RC_NONE)) begin : g_ro
        assign stb_w[c] = 1'b0;
      end else begin : g_rw
        assign stb_w[c] = wr_go && (int'(bank_w) == b) && (int'(code_w) == c);
      end
    end

    gpio_bank_regs #(.LIVE(live_mask(NUM_PINS, b))) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (stb_w),
      .wdata  (req_wdata),
      .lvl    (lvl_v[b*BANK_W +: BANK_W]),
      .en_o   (en_v[b*BANK_W +: BANK_W]),
      .dout_o (dout_v[b*BANK_W +: BANK_W]),
      .dir_o  (dir_v[b*BANK_W +: BANK_W]),
      .mask_o (mask_v[b*BANK_W +: BANK_W]),
      .edge_o (edge_v[b*BANK_W +: BANK_W]),
      .stat_o (stat_v[b*BANK_W +: BANK_W]),
      .pend_o (pend_v[b])
    );
  end

  gpio_rd_mux #(.NB(NB), .BSEL_W(BSEL_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_go),
    .code    (code_w),
    .bank    (bank_w),
    .en_v    (en_v),
    .dout_v  (dout_v),
    .dir_v   (dir_v),
    .lvl_v   (lvl_v),
    .mask_v  (mask_v),
    .stat_v  (stat_v),
    .edge_v  (edge_v),
    .rd_data (rd_data)
  );

  assign drive_v = en_v & ~dir_v;
  assign pad_oe  = drive_v[NUM_PINS-1:0];
  assign pad_out = drive_v[NUM_PINS-1:0] & dout_v[NUM_PINS-1:0];
  assign irq     = |pend_v;

  AST_IRQ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(en_v & ~mask_v) != '0)); // R10
  AST_DRIVE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|pad_oe) |-> (en_v != '0)); // R3
endmodule

// File: tb/sim_gpio_banked.sv
module sim_gpio_banked;
  localparam int NP = 102;
  localparam int BW = 2;
  localparam int AW = 3 + BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [31:0]   rd_data;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_banked #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  localparam int C_EN = 0, C_OUT = 1, C_DIR = 2, C_LVL = 3, C_MSK = 4, C_ST = 5, C_EDG = 6, C_NONE = 7;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int code, input int bank, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1;
    req_addr = AW'((code << BW) | bank); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int code, input int bank, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0;
    req_addr = AW'((code << BW) | bank);
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data;
  endtask

  task automatic set_pad(input int p, input logic v);
    @(negedge clk);
    pad_in[p] = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(C_EN, 0, d);  chk("R1 enable bank0", d, 32'h0);
    rd(C_ST, 1, d);  chk("R1 status bank1", d, 32'h0);
    rd(C_DIR, 3, d); chk("R1 direction bank3", d, 32'h0);
    chk("R1 pad_oe", {31'h0, |pad_oe}, 32'h0);
    chk("R1 pad_out", {31'h0, |pad_out}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_output();
    logic [31:0] d;
    wr(C_EN, 0, 32'h0000_000F);
    wr(C_DIR, 0, 32'h0000_0002);
    wr(C_OUT, 0, 32'h0000_0017);
    chk("R3 pad_oe bank0", pad_oe[31:0], 32'h0000_000D);
    chk("R3 pad_out bank0", pad_out[31:0], 32'h0000_0005);
    rd(C_OUT, 0, d); chk("R2 readback output data", d, 32'h0000_0017);
  endtask

  task automatic t_input();
    logic [31:0] d;
    set_pad(40, 1'b1);
    pad_in[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    rd(C_LVL, 1, d); chk("R4 level bank1 (disabled pin)", d, 32'h0000_0100);
    rd(C_LVL, 0, d); chk("R4 level bank0 (output pin)", d, 32'h0000_0001);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    wr(C_EN, 1, 32'h0000_0100);
    wr(C_DIR, 1, 32'h0000_0100);
    wr(C_EDG, 1, 32'h0000_0100);
    set_pad(40, 1'b0);
    settle();
    chk("R5 falling ignored when rising selected", {31'h0, irq}, 32'h0);
    set_pad(40, 1'b1);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R5 not pending before third edge", {31'h0, irq}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R5 irq at third edge", {31'h0, irq}, 32'h1);
    rd(C_ST, 1, d); chk("R5 rising status", d, 32'h0000_0100);
    wr(C_ST, 1, 32'hFFFF_FFFF);
    rd(C_ST, 1, d); chk("R7 ones keep", d, 32'h0000_0100);
    wr(C_ST, 1, 32'hFFFF_FEFF);
    rd(C_ST, 1, d); chk("R7 zero clears", d, 32'h0);
    chk("R10 irq low after clear", {31'h0, irq}, 32'h0);
    wr(C_EDG, 1, 32'h0);
    set_pad(40, 1'b0);
    settle();
    rd(C_ST, 1, d); chk("R5 falling status", d, 32'h0000_0100);
    wr(C_ST, 1, 32'h0);
  endtask

  task automatic t_gating();
    logic [31:0] d;
    wr(C_MSK, 1, 32'h0000_0100);
    set_pad(40, 1'b1); settle();
    set_pad(40, 1'b0); settle();
    rd(C_ST, 1, d); chk("R6 masked pin quiet", d, 32'h0);
    wr(C_MSK, 1, 32'h0);
    wr(C_EN, 1, 32'h0);
    set_pad(40, 1'b1); settle();
    set_pad(40, 1'b0); settle();
    rd(C_ST, 1, d); chk("R6 disabled pin quiet", d, 32'h0);
    chk("R6 irq low", {31'h0, irq}, 32'h0);
    wr(C_EN, 1, 32'h0000_0100);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    wr(C_EDG, 1, 32'h0000_0100);
    set_pad(40, 1'b1);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1;
    req_addr = AW'((C_ST << BW) | 1); req_wdata = 32'h0;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd(C_ST, 1, d); chk("R8 set beats clear", d, 32'h0000_0100);
    wr(C_ST, 1, 32'h0);
    set_pad(40, 1'b0); settle();
  endtask

  task automatic t_last_bank();
    logic [31:0] d;
    wr(C_EN, 3, 32'hFFFF_FFFF);
    wr(C_DIR, 3, 32'hFFFF_FFFF);
    wr(C_EDG, 3, 32'hFFFF_FFFF);
    rd(C_EN, 3, d); chk("R9 spare bits hold", d, 32'hFFFF_FFFF);
    set_pad(101, 1'b1); settle();
    rd(C_ST, 3, d); chk("R9 only real pin pending", d, 32'h0000_0020);
    chk("R10 irq from last bank", {31'h0, irq}, 32'h1);
    wr(C_ST, 3, 32'h0);
    chk("R10 irq cleared", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(C_LVL, 0, 32'hFFFF_FFFF);
    rd(C_LVL, 0, d); chk("R11 level write ignored", d, 32'h0000_0001);
    wr(C_NONE, 0, 32'hFFFF_FFFF);
    rd(C_NONE, 0, d); chk("R11 code 7 reads zero", d, 32'h0);
    rd(C_EN, 0, d); chk("R11 enable untouched", d, 32'h0000_000F);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_output();
    t_input();
    t_edges();
    t_gating();
    t_set_wins();
    t_last_bank();
    t_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule